// File: doc/BRIEF.md
# Programmable Local Countdown Timer

This block is the local timer of a per-core interrupt controller. Software loads an initial count, and the block counts it down once per prescaled tick. Each time the count runs out, the block records one pending timer event. The prescaler ratio comes from a 4-bit divide code. A mode bit in the timer's entry of a small vector table selects one of two behaviours: the countdown stops at zero (one-shot), or it reloads for another full period (periodic). The current count can be read at any time.

The pending events are offered on an interrupt output. An event is offered only while the timer entry is unmasked and the unit is enabled. A consume strobe takes one event. Turning the unit off masks every entry of the vector table and drops all pending events. Passing the interrupt vector on to a core is left to the surrounding logic.

Top module: `lct_timer`

## Requirements
- R1: After reset the current count, the pending count and the interrupt output are 0. Every mask bit is 1, the unit is disabled, the active divide ratio is 2 and the timer entry is one-shot.
- R2: The divide ratio is 2^e, where e = ({div_code[3], div_code[1:0]} + 1) mod 8. Code 4'b1011 gives a ratio of 1, 4'b0000 gives 2, 4'b0011 gives 16 and 4'b1010 gives 128. Bit 2 of the code is ignored.
- R3: A write of initial count V (non-zero) makes the pending count rise exactly V*D clock cycles after the write edge, where D is the ratio.
- R4: An initial count of 0 stops the timer. The current count then reads 0 and no expiry occurs.
- R5: A write of the initial count cancels the running countdown, clears the pending count, restarts the prescaler and loads the staged divide ratio. The next expiry is timed from this write only.
- R6: In periodic mode (entry 0 periodic bit = 1) an expiry reloads the current count with V, so expiries recur every V*D cycles.
- R7: In one-shot mode the current count is 0 after the expiry, and no further expiry follows.
- R8: Each expiry adds one to the pending count. The count saturates at 2^PEND_W-1.
- R9: irq is 1 when the pending count is non-zero, entry 0 is unmasked and the unit is enabled. take lowers the pending count by one only while irq is 1. Otherwise take has no effect.
- R10: Writing the enable bit as 0 sets every mask bit and clears the pending count.
- R11: An entry write stores its mask bit as given while the unit is enabled. While the unit is disabled, the stored mask bit is forced to 1.
- R12: A divide-code write is staged. It becomes the active ratio at the next prescaler wrap, so the tick in progress keeps the old ratio.
- R13: While running, the current count falls by one every D cycles and never by more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_wr | input | 1 | Write strobe for the initial count |
| init_val | input | CNT_W | Initial count value |
| div_wr | input | 1 | Write strobe for the divide code |
| div_code | input | 4 | Divide code (see R2) |
| ent_wr | input | 1 | Vector-table entry write strobe |
| ent_idx | input | $clog2(N_ENT) | Entry index; entry 0 is the timer |
| ent_mask | input | 1 | Mask bit to write |
| ent_periodic | input | 1 | Periodic mode bit (stored for entry 0 only) |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable value |
| take | input | 1 | Consume one pending event |
| cur_count | output | CNT_W | Current count readback |
| pend_count | output | PEND_W | Pending timer events |
| irq | output | 1 | Deliverable pending event |
| mask_o | output | N_ENT | Mask bits of all entries |
| unit_en | output | 1 | Unit enable state |

## Verification
The bench builds the block with CNT_W=16, PEND_W=2 and N_ENT=4. With a 2-bit pending counter, saturation at 3 is reached after a few short periodic expiries. Four entries let the tests observe masking on entries other than the timer. The default width keeps the full divide range, up to 128, within a few hundred cycles per expiry.

// File: rtl/lct_pkg.sv
// Shared types and the divide-code decode for the local countdown timer.
// Assumes a 4-bit divide code; bit 2 carries no meaning.
package lct_pkg;

    typedef logic [2:0] div_exp_t;

    // Map a divide code to the exponent of its power-of-two ratio (wraps mod 8).
    function automatic div_exp_t div_exp(input logic [3:0] code);
        div_exp_t e;
        e = {code[3], code[1:0]} + 3'd1;
        return e;
    endfunction

endpackage

// File: rtl/lct_prescaler.sv
// Prescaler: counts bus clocks and emits one tick per divide period.
// Assumes: a divide write is staged and becomes active at the next wrap;
// restart clears the count and loads the staged ratio at once.
module lct_prescaler (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       div_wr,
    input  logic [3:0] div_code,
    input  logic       restart,
    output logic       tick
);
    import lct_pkg::*;

    localparam int PRE_W = 8;

    div_exp_t          staged_q;
    div_exp_t          active_q;
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  limit;
    logic              wrap;

    // Last count value of the current prescale period.
    always_comb begin
        limit = (PRE_W'(1) << active_q) - PRE_W'(1);
        wrap  = (pre_q >= limit);
        tick  = wrap && !restart;
    end

    // Staging of the divide code, prescale count and ratio handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            staged_q <= div_exp(4'b0000);
            active_q <= div_exp(4'b0000);
            pre_q    <= '0;
        end else begin
            if (div_wr) begin
                staged_q <= div_exp(div_code);
            end
            if (restart || wrap) begin
                pre_q    <= '0;
                active_q <= staged_q;
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

endmodule

// File: rtl/lct_counter.sv
// Main down-counter: loads the initial count, decrements on each tick and
// flags expiry. Assumes a zero count means stopped.
module lct_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cur_q;

    // Expiry when the last unit is consumed by a tick.
    always_comb begin
        expire = tick && !load && (cur_q == CNT_W'(1));
        cur    = cur_q;
    end

    // Initial count storage and countdown with reload or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            cur_q  <= '0;
        end else if (load) begin
            init_q <= load_val;
            cur_q  <= load_val;
        end else if (expire) begin
            cur_q <= periodic ? init_q : '0;
        end else if (tick && (cur_q != '0)) begin
            cur_q <= cur_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/lct_pending.sv
// Saturating pending-event counter with gated consumption.
// Assumes clear wins over every other request.
module lct_pending #(
    parameter int PEND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              take,
    input  logic              gate,
    input  logic              clr,
    output logic [PEND_W-1:0] cnt,
    output logic              ready
);
    localparam logic [PEND_W-1:0] MAX = '1;

    logic [PEND_W-1:0] cnt_q;
    logic              dec;

    // Event is offered only when something is pending and delivery is allowed.
    always_comb begin
        ready = (cnt_q != '0) && gate;
        dec   = take && ready;
        cnt   = cnt_q;
    end

    // Count expiries up (saturating) and consumed events down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && !dec) begin
            if (cnt_q != MAX) begin
                cnt_q <= cnt_q + PEND_W'(1);
            end
        end else if (dec && !inc) begin
            cnt_q <= cnt_q - PEND_W'(1);
        end
    end

endmodule

// File: rtl/lct_vtable.sv
// Vector-table mask bits, timer mode bit and the unit enable.
// Assumes entry 0 is the timer entry; only it stores a mode bit.
module lct_vtable #(
    parameter int N_ENT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_wr,
    input  logic                     en_val,
    input  logic                     ent_wr,
    input  logic [$clog2(N_ENT)-1:0] ent_idx,
    input  logic                     ent_mask,
    input  logic                     ent_periodic,
    output logic [N_ENT-1:0]         mask,
    output logic                     periodic,
    output logic                     enable
);
    logic [N_ENT-1:0] mask_q;
    logic             per_q;
    logic             en_q;

    always_comb begin
        mask     = mask_q;
        periodic = per_q;
        enable   = en_q;
    end

    // Unit enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_wr) begin
            en_q <= en_val;
        end
    end

    // Timer mode bit, held by entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= 1'b0;
        end else if (ent_wr && (ent_idx == '0)) begin
            per_q <= ent_periodic;
        end
    end

    // One mask bit per entry; forced on while disabled or on disable.
    for (genvar g = 0; g < N_ENT; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[g] <= 1'b1;
            end else if (en_wr && !en_val) begin
                mask_q[g] <= 1'b1;
            end else if (ent_wr && (ent_idx == ($clog2(N_ENT))'(g))) begin
                mask_q[g] <= ent_mask || !en_q;
            end
        end
    end

endmodule

// File: rtl/lct_timer.sv
// Local countdown timer top: prescaler, down-counter, pending counter and
// vector-table state. Assumes single-cycle register write strobes.
module lct_timer #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4,
    parameter int N_ENT  = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_wr,
    input  logic [CNT_W-1:0]         init_val,
    input  logic                     div_wr,
    input  logic [3:0]               div_code,
    input  logic                     ent_wr,
    input  logic [$clog2(N_ENT)-1:0] ent_idx,
    input  logic                     ent_mask,
    input  logic                     ent_periodic,
    input  logic                     en_wr,
    input  logic                     en_val,
    input  logic                     take,
    output logic [CNT_W-1:0]         cur_count,
    output logic [PEND_W-1:0]        pend_count,
    output logic                     irq,
    output logic [N_ENT-1:0]         mask_o,
    output logic                     unit_en
);
    logic tick;
    logic expire;
    logic periodic;
    logic pend_clr;
    logic gate;

    // Pending events drop on restart and on disable; delivery needs entry 0 open.
    always_comb begin
        pend_clr = init_wr || (en_wr && !en_val);
        gate     = !mask_o[0] && unit_en;
    end

    lct_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_code (div_code),
        .restart  (init_wr),
        .tick     (tick)
    );

    lct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (init_val),
        .tick     (tick),
        .periodic (periodic),
        .cur      (cur_count),
        .expire   (expire)
    );

    lct_pending #(.PEND_W(PEND_W)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (expire),
        .take  (take),
        .gate  (gate),
        .clr   (pend_clr),
        .cnt   (pend_count),
        .ready (irq)
    );

    lct_vtable #(.N_ENT(N_ENT)) u_vt (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_wr        (en_wr),
        .en_val       (en_val),
        .ent_wr       (ent_wr),
        .ent_idx      (ent_idx),
        .ent_mask     (ent_mask),
        .ent_periodic (ent_periodic),
        .mask         (mask_o),
        .periodic     (periodic),
        .enable       (unit_en)
    );

endmodule

// File: rtl/lct_timer_chk.sv
// Property checker for lct_timer, observing only its ports.
module lct_timer_chk #(
    parameter int CNT_W  = 32,
    parameter int PEND_W = 4,
    parameter int N_ENT  = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     init_wr,
    input logic                     ent_wr,
    input logic [$clog2(N_ENT)-1:0] ent_idx,
    input logic                     en_wr,
    input logic                     en_val,
    input logic                     take,
    input logic [CNT_W-1:0]         cur_count,
    input logic [PEND_W-1:0]        pend_count,
    input logic                     irq,
    input logic [N_ENT-1:0]         mask_o,
    input logic                     unit_en
);
    p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count == '0 && !init_wr) |=> (cur_count == '0));

    p_restart_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (pend_count == '0));

    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((&pend_count) && !take && !init_wr && !en_wr) |=> (&pend_count));

    p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !init_wr && !en_wr) |=> (pend_count >= $past(pend_count)));

    p_disable_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && !en_val) |=> ((&mask_o) && pend_count == '0));

    p_forced_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_wr && !unit_en && !en_wr) |=> mask_o[$past(ent_idx)]);

    p_step_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count > CNT_W'(1) && !init_wr) |=>
        (cur_count == $past(cur_count) || cur_count == $past(cur_count) - CNT_W'(1)));

endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W), .N_ENT(N_ENT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_wr    (init_wr),
    .ent_wr     (ent_wr),
    .ent_idx    (ent_idx),
    .en_wr      (en_wr),
    .en_val     (en_val),
    .take       (take),
    .cur_count  (cur_count),
    .pend_count (pend_count),
    .irq        (irq),
    .mask_o     (mask_o),
    .unit_en    (unit_en)
);

// File: tb/lct_timer_test.sv
module lct_timer_test;
    localparam int CNT_W  = 16;
    localparam int PEND_W = 2;
    localparam int N_ENT  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             init_wr = 1'b0;
    logic [CNT_W-1:0] init_val = '0;
    logic             div_wr = 1'b0;
    logic [3:0]       div_code = '0;
    logic             ent_wr = 1'b0;
    logic [1:0]       ent_idx = '0;
    logic             ent_mask = 1'b0;
    logic             ent_periodic = 1'b0;
    logic             en_wr = 1'b0;
    logic             en_val = 1'b0;
    logic             take = 1'b0;
    logic [CNT_W-1:0] cur_count;
    logic [PEND_W-1:0] pend_count;
    logic             irq;
    logic [N_ENT-1:0] mask_o;
    logic             unit_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int prev_pend = 0;
    int expq[$];
    int c0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lct_timer #(.CNT_W(CNT_W), .PEND_W(PEND_W), .N_ENT(N_ENT)) uut (
        .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .init_val(init_val),
        .div_wr(div_wr), .div_code(div_code), .ent_wr(ent_wr), .ent_idx(ent_idx),
        .ent_mask(ent_mask), .ent_periodic(ent_periodic), .en_wr(en_wr),
        .en_val(en_val), .take(take), .cur_count(cur_count),
        .pend_count(pend_count), .irq(irq), .mask_o(mask_o), .unit_en(unit_en)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int dval(input logic [3:0] code);
        logic [2:0] e;
        e = {code[3], code[1:0]} + 3'd1;
        return 1 << e;
    endfunction

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: each rise of the pending count must match the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (int'(pend_count) > prev_pend) begin
                checks++;
                if (expq.size() == 0) begin
                    failures++;
                    $display("FAIL R3 unexpected expiry actual=%0d expected=none", cyc);
                end else begin
                    int e;
                    e = expq.pop_front();
                    if (e != cyc) begin
                        failures++;
                        $display("FAIL R3 expiry cycle actual=%0d expected=%0d", cyc, e);
                    end
                end
            end
            prev_pend = int'(pend_count);
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic write_div(input logic [3:0] code);
        @(negedge clk); div_wr = 1'b1; div_code = code;
        @(negedge clk); div_wr = 1'b0;
    endtask

    // Driver: restart the timer and queue the expected expiry cycles.
    task automatic write_init(input int v, input int n, input int d);
        @(negedge clk); init_wr = 1'b1; init_val = CNT_W'(v);
        expq.delete();
        @(negedge clk); init_wr = 1'b0;
        c0 = cyc;
        for (int k = 1; k <= n; k++) expq.push_back(c0 + k * v * d);
    endtask

    task automatic write_ent(input int idx, input logic m, input logic p);
        @(negedge clk); ent_wr = 1'b1; ent_idx = 2'(idx); ent_mask = m; ent_periodic = p;
        @(negedge clk); ent_wr = 1'b0;
    endtask

    task automatic write_en(input logic v);
        @(negedge clk); en_wr = 1'b1; en_val = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic pulse_take();
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
    endtask

    initial begin
        logic [3:0] codes [5];
        int exp_d [5];
        codes = '{4'b1011, 4'b0000, 4'b0100, 4'b0011, 4'b1010};
        exp_d = '{1, 2, 2, 16, 128};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 cur", int'(cur_count), 0);
        check("R1 pend", int'(pend_count), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 mask", int'(mask_o), 15);
        check("R1 enable", int'(unit_en), 0);
        // R1 default ratio 2: one-shot 3 counts -> 6 cycles
        write_init(3, 1, 2);
        wait_until(c0 + 8);
        check("R1 default divide expiry", expq.size(), 0);

        // R2/R3/R7 divide table in one-shot mode
        foreach (codes[i]) begin
            int d;
            d = dval(codes[i]);
            check("R2 divide decode", d, exp_d[i]);
            write_div(codes[i]);
            write_init(3, 1, d);
            wait_until(c0 + 2 * 3 * d + 2);
            check("R3 expiry seen", expq.size(), 0);
            check("R7 one-shot single expiry", int'(pend_count), 1);
            check("R7 one-shot count zero", int'(cur_count), 0);
        end

        // R13 stepping at ratio 2
        write_div(4'b0000);
        write_init(5, 1, 2);
        wait_until(c0 + 1);
        check("R13 cur at start", int'(cur_count), 5);
        wait_until(c0 + 2);
        check("R13 cur after one tick", int'(cur_count), 4);
        wait_until(c0 + 3);
        check("R13 cur holds", int'(cur_count), 4);
        wait_until(c0 + 12);

        // R12 deferred divide change: ratio 4, then ratio 1 staged mid-tick
        write_div(4'b0001);
        @(negedge clk); init_wr = 1'b1; init_val = CNT_W'(3); expq.delete();
        @(negedge clk); init_wr = 1'b0; div_wr = 1'b1; div_code = 4'b1011;
        c0 = cyc;
        expq.push_back(c0 + 6);
        @(negedge clk); div_wr = 1'b0;
        wait_until(c0 + 3);
        check("R12 old ratio kept", int'(cur_count), 3);
        wait_until(c0 + 4);
        check("R12 first tick", int'(cur_count), 2);
        wait_until(c0 + 10);
        check("R12 expiry with new ratio", expq.size(), 0);

        // R5 restart cancels running countdown (ratio 1)
        write_init(10, 1, 1);
        wait_until(c0 + 5);
        write_init(3, 1, 1);
        wait_until(c0 + 12);
        check("R5 single expiry after restart", int'(pend_count), 1);
        check("R5 queue drained", expq.size(), 0);

        // R6/R8 periodic at ratio 2
        write_ent(0, 1'b1, 1'b1);
        write_div(4'b0000);
        write_init(4, 3, 2);
        wait_until(c0 + 8);
        check("R6 reload on expiry", int'(cur_count), 4);
        wait_until(c0 + 34);
        check("R8 saturated", int'(pend_count), 3);
        check("R6 three expiries", expq.size(), 0);

        // R4/R5 zero count stops
        write_init(0, 0, 1);
        check("R5 pend cleared", int'(pend_count), 0);
        check("R4 cur zero", int'(cur_count), 0);
        repeat (40) @(negedge clk);
        check("R4 no expiry", int'(pend_count), 0);
        check("R4 still zero", int'(cur_count), 0);

        // R9/R10/R11 enable and masking
        write_en(1'b1);
        check("R10 enabled", int'(unit_en), 1);
        write_ent(0, 1'b0, 1'b1);
        check("R11 unmask while enabled", int'(mask_o), 14);
        write_div(4'b1011);
        write_init(2, 3, 1);
        wait_until(c0 + 12);
        write_ent(0, 1'b0, 1'b0);
        repeat (6) @(negedge clk);
        check("R8 pend saturated", int'(pend_count), 3);
        check("R9 irq offered", int'(irq), 1);
        pulse_take();
        check("R9 take consumes", int'(pend_count), 2);
        write_ent(0, 1'b1, 1'b0);
        check("R9 irq masked", int'(irq), 0);
        pulse_take();
        check("R9 take ignored when masked", int'(pend_count), 2);
        write_ent(0, 1'b0, 1'b0);
        write_en(1'b0);
        check("R10 all masked", int'(mask_o), 15);
        check("R10 pend cleared", int'(pend_count), 0);
        check("R10 irq low", int'(irq), 0);
        write_ent(2, 1'b0, 1'b0);
        check("R11 mask forced when disabled", int'(mask_o[2]), 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule